// File: doc/BRIEF.md
# Read-After-Write Hazard Guard

This block sits between a host bus master and a memory-mapped peripheral register file. It keeps a read from reaching the peripheral too soon after a write whose effect the read might observe. It remembers the class of the register last written and its address. It also counts the clock cycles since that write. The required gap depends on both the written register and the register about to be read.

When a read arrives before its gap has passed, the block fills the time in one of two ways, chosen by the `fill_mode` pin. In stall mode it holds the request off through the valid/ready handshake. In dummy mode it issues throw-away reads of a harmless test register, spaced one bus cycle apart, and then performs the real read. A read that arrives after the gap has passed goes straight through.

Host requests use valid/ready. A request stays presented, with stable fields, until `host_req_ready` is high in the same cycle as `host_req_valid`. Read data comes back combinationally in the cycle the read is accepted, flagged by `host_rsp_valid`. The response has no back-pressure. The peripheral side is a single-cycle strobe with combinational read data. Gaps are written in nanoseconds and turned into cycles by rounding up against `CLK_NS`. With the defaults (`CLK_NS` = 10, `DUMMY_CYC` = 5), the cycle counts below apply.

Top module: `raw_guard`

## Requirements
- R1: After reset no hazard is pending. A read presented in the first cycle after reset is accepted in that same cycle. No peripheral access happens while no request is presented.
- R2: After a write, a read of the same address needs a gap of 5 cycles (45 ns). The gap counts the clock edges from the write's acceptance to the read's acceptance. This applies to any register, and when a table entry below also applies, the larger of the two gaps is used.
- R3: Write to the interrupt configuration register (address 0x10), then read it: gap of 6 cycles (60 ns).
- R4: Write to the interrupt enable register (0x18): a read of the configuration register needs 9 cycles (90 ns), and a read of the interrupt status register (0x14) needs 6 cycles (60 ns).
- R5: Write to the status register (0x14): a read of the configuration register needs 18 cycles (180 ns), and a read of the status register needs 17 cycles (170 ns).
- R6: Write to the power control register (0x20): a read of the power control register needs 17 cycles (165 ns), a read of the configuration register 17 cycles (170 ns), and a read of the status register 16 cycles (160 ns).
- R7: A read of a different address with no entry for the last-written class is accepted with no wait.
- R8: Stall mode (`fill_mode`=0): while the gap is unmet, `host_req_ready` is low and the peripheral sees no access. The read is accepted in the first cycle the gap is met.
- R9: Dummy mode (`fill_mode`=1): a read that arrives r cycles early causes ceil(r / `DUMMY_CYC`) reads of the test register (address 0x00). The first is issued in the arrival cycle and the others follow every `DUMMY_CYC` cycles. Their data is not returned (`host_rsp_valid` stays low). The real read is accepted `DUMMY_CYC` cycles after the last dummy read.
- R10: A read whose gap has already passed when it is presented is accepted in that cycle in both modes, with no dummy reads.
- R11: A new write restarts the elapsed count and replaces the stored class and address. The elapsed count saturates and does not wrap, so a long idle period never brings a stall back.
- R12: Writes are accepted in the cycle they are presented and reach the peripheral unchanged. Read data is returned as the peripheral supplies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_mode | input | 1 | 0 = stall early reads, 1 = fill with dummy test reads |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Request accepted this cycle |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_addr | input | ADDR_W | Register address |
| host_req_wdata | input | DATA_W | Write data |
| host_rsp_valid | output | 1 | Read data valid (real reads only) |
| host_rsp_data | output | DATA_W | Read data |
| per_en | output | 1 | Peripheral access strobe |
| per_write | output | 1 | Peripheral write |
| per_addr | output | ADDR_W | Peripheral address |
| per_wdata | output | DATA_W | Peripheral write data |
| per_rdata | input | DATA_W | Peripheral read data, same cycle |

## Verification
Every table pair is tried with the read presented right after the write, which separates one pair's gap from another's. Each pair runs in both fill modes, so the tests show whether waiting and dummy filling reach the same deadline. Idle lengths just short of, equal to and well past the gap separate an off-by-one in the deadline, a missing zero-latency path and a wrapping counter. Pairs with no entry and pairs that differ only in address check the same-register rule. A write placed in the middle of a pending gap shows whether the stored class is replaced.

// File: rtl/raw_guard_pkg.sv
package raw_guard_pkg;

  typedef enum logic [2:0] {
    RC_OTHER = 3'd0,
    RC_CFG   = 3'd1,
    RC_EN    = 3'd2,
    RC_STS   = 3'd3,
    RC_PWR   = 3'd4
  } rclass_t;

  // required gaps in nanoseconds, per (written, read) pair
  localparam int NS_SAME    = 45;
  localparam int NS_CFG_CFG = 60;
  localparam int NS_EN_CFG  = 90;
  localparam int NS_EN_STS  = 60;
  localparam int NS_STS_CFG = 180;
  localparam int NS_STS_STS = 170;
  localparam int NS_PWR_PWR = 165;
  localparam int NS_PWR_CFG = 170;
  localparam int NS_PWR_STS = 160;
  localparam int NS_MAX     = 180;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/raw_classify.sv
module raw_classify
  import raw_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_CFG = 8'h10,
  parameter logic [ADDR_W-1:0] ADDR_STS = 8'h14,
  parameter logic [ADDR_W-1:0] ADDR_EN  = 8'h18,
  parameter logic [ADDR_W-1:0] ADDR_PWR = 8'h20
) (
  input  logic [ADDR_W-1:0] addr,
  output rclass_t           cls
);
  always_comb begin
    if (addr == ADDR_CFG)      cls = RC_CFG;
    else if (addr == ADDR_STS) cls = RC_STS;
    else if (addr == ADDR_EN)  cls = RC_EN;
    else if (addr == ADDR_PWR) cls = RC_PWR;
    else                       cls = RC_OTHER;
  end
endmodule

// File: rtl/raw_gap_table.sv
module raw_gap_table
  import raw_guard_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int NEED_W = 5
) (
  input  rclass_t           wcls,
  input  rclass_t           rcls,
  input  logic              same,
  output logic [NEED_W-1:0] need
);
  localparam logic [NEED_W-1:0] C_SAME    = NEED_W'(ns2cyc(NS_SAME,    CLK_NS));
  localparam logic [NEED_W-1:0] C_CFG_CFG = NEED_W'(ns2cyc(NS_CFG_CFG, CLK_NS));
  localparam logic [NEED_W-1:0] C_EN_CFG  = NEED_W'(ns2cyc(NS_EN_CFG,  CLK_NS));
  localparam logic [NEED_W-1:0] C_EN_STS  = NEED_W'(ns2cyc(NS_EN_STS,  CLK_NS));
  localparam logic [NEED_W-1:0] C_STS_CFG = NEED_W'(ns2cyc(NS_STS_CFG, CLK_NS));
  localparam logic [NEED_W-1:0] C_STS_STS = NEED_W'(ns2cyc(NS_STS_STS, CLK_NS));
  localparam logic [NEED_W-1:0] C_PWR_PWR = NEED_W'(ns2cyc(NS_PWR_PWR, CLK_NS));
  localparam logic [NEED_W-1:0] C_PWR_CFG = NEED_W'(ns2cyc(NS_PWR_CFG, CLK_NS));
  localparam logic [NEED_W-1:0] C_PWR_STS = NEED_W'(ns2cyc(NS_PWR_STS, CLK_NS));

  logic [NEED_W-1:0] pair;

  always_comb begin
    pair = '0;
    case (wcls)
      RC_CFG: if (rcls == RC_CFG) pair = C_CFG_CFG;
      RC_EN: begin
        if (rcls == RC_CFG)      pair = C_EN_CFG;
        else if (rcls == RC_STS) pair = C_EN_STS;
      end
      RC_STS: begin
        if (rcls == RC_CFG)      pair = C_STS_CFG;
        else if (rcls == RC_STS) pair = C_STS_STS;
      end
      RC_PWR: begin
        if (rcls == RC_PWR)      pair = C_PWR_PWR;
        else if (rcls == RC_CFG) pair = C_PWR_CFG;
        else if (rcls == RC_STS) pair = C_PWR_STS;
      end
      default: pair = '0;
    endcase
    need = (same && (C_SAME > pair)) ? C_SAME : pair;
  end
endmodule

// File: rtl/raw_gap_timer.sv
module raw_gap_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '1;
    else if (restart)    cnt <= CNT_W'(1);
    else if (cnt != '1)  cnt <= cnt + 1'b1;
  end

  // R11: a write restarts the count at one
  assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == CNT_W'(1)));

  // R11: once saturated the count holds until the next write
  assert_saturate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == '1) && !restart) |=> (cnt == '1));
endmodule

// File: rtl/raw_dummy_seq.sv
module raw_dummy_seq #(
  parameter int CNT_W     = 5,
  parameter int DUMMY_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] remaining,
  output logic             busy,
  output logic             fire
);
  localparam int SP_W = (DUMMY_CYC > 1) ? $clog2(DUMMY_CYC) : 1;
  localparam int N_W  = CNT_W + 1;

  logic [CNT_W-1:0] left_q;
  logic [SP_W-1:0]  space_q;
  logic [N_W-1:0]   nsum;
  logic [CNT_W-1:0] n_dummy;

  always_comb begin
    nsum    = {1'b0, remaining} + N_W'(DUMMY_CYC - 1);
    n_dummy = CNT_W'(nsum / N_W'(DUMMY_CYC));
  end

  assign busy = (left_q != '0) || (space_q != '0);
  assign fire = (start && !busy) || ((space_q == '0) && (left_q != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q  <= '0;
      space_q <= '0;
    end else if (start && !busy) begin
      left_q  <= n_dummy - 1'b1;
      space_q <= SP_W'(DUMMY_CYC - 1);
    end else if (space_q != '0) begin
      space_q <= space_q - 1'b1;
    end else if (left_q != '0) begin
      left_q  <= left_q - 1'b1;
      space_q <= SP_W'(DUMMY_CYC - 1);
    end
  end

  // R9: a new sequence only starts from idle
  assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  generate
    if (DUMMY_CYC > 1) begin : g_spacing
      // R9: dummy reads are spaced at least one bus cycle apart
      assert_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    end
  endgenerate
endmodule

// File: rtl/raw_guard.sv
module raw_guard
  import raw_guard_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CLK_NS    = 10,
  parameter int DUMMY_CYC = 5,
  parameter logic [ADDR_W-1:0] ADDR_CFG  = 8'h10,
  parameter logic [ADDR_W-1:0] ADDR_STS  = 8'h14,
  parameter logic [ADDR_W-1:0] ADDR_EN   = 8'h18,
  parameter logic [ADDR_W-1:0] ADDR_PWR  = 8'h20,
  parameter logic [ADDR_W-1:0] ADDR_TEST = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_mode,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_write,
  input  logic [ADDR_W-1:0] host_req_addr,
  input  logic [DATA_W-1:0] host_req_wdata,
  output logic              host_rsp_valid,
  output logic [DATA_W-1:0] host_rsp_data,
  output logic              per_en,
  output logic              per_write,
  output logic [ADDR_W-1:0] per_addr,
  output logic [DATA_W-1:0] per_wdata,
  input  logic [DATA_W-1:0] per_rdata
);
  localparam int MAX_CYC = ns2cyc(NS_MAX, CLK_NS);
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);

  rclass_t           wcls_q;
  logic [ADDR_W-1:0] waddr_q;
  rclass_t           cls_now;
  logic              same;
  logic [CNT_W-1:0]  need;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  remaining;
  logic              clear;
  logic              rd_req;
  logic              grant;
  logic              wr_grant;
  logic              dm_start;
  logic              dm_busy;
  logic              dm_fire;

  raw_classify #(
    .ADDR_W(ADDR_W), .ADDR_CFG(ADDR_CFG), .ADDR_STS(ADDR_STS),
    .ADDR_EN(ADDR_EN), .ADDR_PWR(ADDR_PWR)
  ) u_cls (
    .addr (host_req_addr),
    .cls  (cls_now)
  );

  assign same = (waddr_q == host_req_addr);

  raw_gap_table #(.CLK_NS(CLK_NS), .NEED_W(CNT_W)) u_tbl (
    .wcls (wcls_q),
    .rcls (cls_now),
    .same (same),
    .need (need)
  );

  raw_gap_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_grant),
    .cnt     (cnt)
  );

  assign rd_req    = host_req_valid && !host_req_write;
  assign clear     = (cnt >= need);
  assign remaining = clear ? '0 : (need - cnt);
  assign dm_start  = rd_req && !clear && fill_mode && !dm_busy;

  raw_dummy_seq #(.CNT_W(CNT_W), .DUMMY_CYC(DUMMY_CYC)) u_dm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (dm_start),
    .remaining (remaining),
    .busy      (dm_busy),
    .fire      (dm_fire)
  );

  assign grant    = host_req_valid && !dm_busy && (host_req_write || clear);
  assign wr_grant = grant && host_req_write;

  assign host_req_ready = grant;
  assign host_rsp_valid = grant && !host_req_write;
  assign host_rsp_data  = per_rdata;

  assign per_en    = grant || dm_fire;
  assign per_write = wr_grant;
  assign per_addr  = dm_fire ? ADDR_TEST : host_req_addr;
  assign per_wdata = host_req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcls_q  <= RC_OTHER;
      waddr_q <= '0;
    end else if (wr_grant) begin
      wcls_q  <= cls_now;
      waddr_q <= host_req_addr;
    end
  end

  // R8: no real read is returned before the elapsed count meets the table gap
  assert_no_early_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid |-> (cnt >= need));

  // R8: an early read in stall mode is held off and leaves the peripheral idle
  assert_stall_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !clear && !fill_mode && !dm_busy) |-> (!host_req_ready && !per_en));

  // R9: dummy accesses target the test register and return nothing
  assert_dummy_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dm_fire |-> (per_addr == ADDR_TEST && !per_write && !host_rsp_valid));

  // R12: a write is never delayed when no dummy sequence runs
  assert_write_pass_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req_valid && host_req_write && !dm_busy) |-> (per_en && per_write));
endmodule

// File: tb/tb_raw_guard.sv
module tb_raw_guard;
  localparam int CLK_NS = 10;
  localparam int DCYC   = 5;
  localparam logic [7:0] A_CFG = 8'h10, A_STS = 8'h14, A_EN = 8'h18,
                         A_PWR = 8'h20, A_TST = 8'h00, A_X = 8'h30, A_Y = 8'h34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_mode = 1'b0;
  logic host_req_valid = 1'b0;
  logic host_req_ready;
  logic host_req_write = 1'b0;
  logic [7:0] host_req_addr = '0;
  logic [31:0] host_req_wdata = '0;
  logic host_rsp_valid;
  logic [31:0] host_rsp_data;
  logic per_en, per_write;
  logic [7:0] per_addr;
  logic [31:0] per_wdata;
  logic [31:0] per_rdata;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #(CLK_NS/2) clk = ~clk;

  assign per_rdata = 32'hC0DE_0000 | {24'h0, per_addr};

  raw_guard #(.CLK_NS(CLK_NS), .DUMMY_CYC(DCYC)) dut (
    .clk(clk), .rst_n(rst_n), .fill_mode(fill_mode),
    .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
    .host_req_write(host_req_write), .host_req_addr(host_req_addr),
    .host_req_wdata(host_req_wdata), .host_rsp_valid(host_rsp_valid),
    .host_rsp_data(host_rsp_data), .per_en(per_en), .per_write(per_write),
    .per_addr(per_addr), .per_wdata(per_wdata), .per_rdata(per_rdata)
  );

  function automatic int cyc_of(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  // write one register, returns the cycle it was accepted
  task automatic do_write(input logic [7:0] a, output int wc);
    host_req_valid = 1'b1; host_req_write = 1'b1;
    host_req_addr = a; host_req_wdata = 32'h1234_0000 | {24'h0, a};
    #1;
    check(host_req_ready && per_en && per_write && per_addr == a
          && per_wdata == (32'h1234_0000 | {24'h0, a}), "R12 write pass",
          int'(host_req_ready), 1);
    wc = cyc;
    tick();
    host_req_valid = 1'b0; host_req_write = 1'b0;
  endtask

  // write wa, idle cycles, read ra; checks gap, dummy count, response
  task automatic run_pair(input logic [7:0] wa, input logic [7:0] ra, input int idle,
                          input logic mode, input int need, input string req);
    int wc, rc, j0, eg, ed, nd, nrv, guard;
    logic [31:0] data;
    bit badaddr;
    fill_mode = mode;
    do_write(wa, wc);
    for (int i = 0; i < idle; i++) tick();
    host_req_valid = 1'b1; host_req_write = 1'b0; host_req_addr = ra;
    nd = 0; nrv = 0; rc = -1; guard = 0; data = '0; badaddr = 1'b0;
    while (rc < 0 && guard < 300) begin
      #1;
      if (per_en && !host_req_ready) begin
        nd++;
        if (per_addr != A_TST || per_write) badaddr = 1'b1;
      end
      if (host_rsp_valid) nrv++;
      if (host_req_ready) begin rc = cyc; data = host_rsp_data; end
      tick();
      guard++;
    end
    host_req_valid = 1'b0;
    j0 = idle + 1;
    if (j0 >= need) begin eg = j0; ed = 0; end
    else if (!mode) begin eg = need; ed = 0; end
    else begin ed = (need - j0 + DCYC - 1) / DCYC; eg = j0 + ed * DCYC; end
    check(rc - wc == eg, {req, " gap"}, rc - wc, eg);
    check(nd == ed && !badaddr, {req, " dummy reads"}, nd, ed);
    check(nrv == 1 && data == (32'hC0DE_0000 | {24'h0, ra}), {req, " response"},
          int'(data[7:0]), int'(ra));
  endtask

  task automatic t_reset();
    int guard;
    #1;
    check(!per_en && !host_rsp_valid, "R1 idle after reset", int'(per_en), 0);
    host_req_valid = 1'b1; host_req_write = 1'b0; host_req_addr = A_CFG;
    #1;
    check(host_req_ready && host_rsp_valid, "R1 first read immediate", int'(host_req_ready), 1);
    tick();
    host_req_valid = 1'b0;
    guard = 0;
  endtask

  task automatic t_same();
    run_pair(A_X, A_X, 0, 1'b0, cyc_of(45), "R2 same other stall");
    run_pair(A_EN, A_EN, 0, 1'b1, cyc_of(45), "R2 same enable dummy");
    run_pair(A_X, A_X, 3, 1'b0, cyc_of(45), "R2 same short idle");
  endtask

  task automatic t_cfg();
    run_pair(A_CFG, A_CFG, 0, 1'b0, cyc_of(60), "R3 cfg-cfg stall");
    run_pair(A_CFG, A_CFG, 0, 1'b1, cyc_of(60), "R3 cfg-cfg dummy");
  endtask

  task automatic t_en();
    run_pair(A_EN, A_CFG, 0, 1'b0, cyc_of(90), "R4 en-cfg stall");
    run_pair(A_EN, A_CFG, 2, 1'b1, cyc_of(90), "R4 en-cfg dummy");
    run_pair(A_EN, A_STS, 0, 1'b0, cyc_of(60), "R4 en-sts stall");
  endtask

  task automatic t_sts();
    run_pair(A_STS, A_CFG, 0, 1'b0, cyc_of(180), "R5 sts-cfg stall");
    run_pair(A_STS, A_STS, 0, 1'b0, cyc_of(170), "R5 sts-sts stall");
    run_pair(A_STS, A_CFG, 0, 1'b1, cyc_of(180), "R5 sts-cfg dummy");
  endtask

  task automatic t_pwr();
    run_pair(A_PWR, A_PWR, 0, 1'b0, cyc_of(165), "R6 pwr-pwr stall");
    run_pair(A_PWR, A_CFG, 0, 1'b0, cyc_of(170), "R6 pwr-cfg stall");
    run_pair(A_PWR, A_STS, 0, 1'b1, cyc_of(160), "R6 pwr-sts dummy");
  endtask

  task automatic t_none();
    run_pair(A_EN, A_PWR, 0, 1'b0, 0, "R7 en-pwr no entry");
    run_pair(A_X, A_Y, 0, 1'b1, 0, "R7 other-other");
    run_pair(A_CFG, A_STS, 0, 1'b0, 0, "R7 cfg-sts no entry");
  endtask

  task automatic t_stall_edge();
    run_pair(A_STS, A_STS, cyc_of(170) - 2, 1'b0, cyc_of(170), "R8 one cycle early");
    run_pair(A_STS, A_STS, cyc_of(170) - 1, 1'b0, cyc_of(170), "R8 exactly at gap");
  endtask

  task automatic t_dummy_edge();
    run_pair(A_STS, A_STS, cyc_of(170) - 2, 1'b1, cyc_of(170), "R9 one cycle early");
    run_pair(A_PWR, A_STS, 6, 1'b1, cyc_of(160), "R9 partial fill");
  endtask

  task automatic t_late();
    run_pair(A_PWR, A_PWR, 20, 1'b1, cyc_of(165), "R10 late dummy mode");
    run_pair(A_STS, A_CFG, 30, 1'b0, cyc_of(180), "R10 late stall mode");
  endtask

  task automatic t_restart();
    int wc;
    do_write(A_STS, wc);
    for (int i = 0; i < 3; i++) tick();
    run_pair(A_X, A_CFG, 0, 1'b0, 0, "R11 class replaced");
    do_write(A_STS, wc);
    for (int i = 0; i < 25; i++) tick();
    run_pair(A_STS, A_STS, 0, 1'b0, cyc_of(170), "R11 count restarted");
    run_pair(A_STS, A_CFG, 100, 1'b0, cyc_of(180), "R11 saturation no wrap");
  endtask

  initial begin
    #(200000 * CLK_NS);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    rst_n = 1'b1;
    t_reset();
    t_same();
    t_cfg();
    t_en();
    t_sts();
    t_pwr();
    t_none();
    t_stall_edge();
    t_dummy_edge();
    t_late();
    t_restart();
    tick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule